// File: doc/BRIEF.md
# Sensor-Driven Four-Way Signal Controller

This block runs the signals of a four-way crossing that has no turn lanes. The four approaches are paired into two opposing phases, north/south and east/west. Only one phase is served at a time, and the other phase is held at red. Each approach has one road sensor input. When a car waits on a red approach, the controller lets the served phase keep green for a fixed waiting time, shows yellow for a fixed clearance time, and then hands green to the waiting phase. If no car is waiting on the red side, the served phase keeps its green for as long as that lasts.

Each approach drives a single one-colour lamp, so the colour is shown as a pattern. Green is steady on. Yellow flashes at 2 Hz. Red flashes at 4 Hz. All timing is derived from one parameter, the number of clock cycles per second: a simulation can use a small value, and a 100 MHz board uses 100,000,000. The sensor bits are brought into the clock domain by a two-flop synchroniser.

Top module: `sig_ctrl_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears every counter and flash toggle. In the cycle after that edge `lamp` reads 4'b0011 (north/south green, east/west red with the fast toggle at 0). After release, the east/west lamps stay low for the first eighth-second (TICKS_PER_SEC/8 cycles) and then go high.
- R2: A lamp whose approach is green is held at 1 on every cycle.
- R3: A lamp whose approach is yellow toggles every TICKS_PER_SEC/4 cycles (2 Hz, 50% duty).
- R4: A lamp whose approach is red toggles every TICKS_PER_SEC/8 cycles (4 Hz, 50% duty).
- R5: A synchronised sensor seen on a red approach starts a wait of exactly WAIT_SEC seconds (default 5). During the wait the served phase stays green. After the wait the served phase turns yellow.
- R6: Yellow lasts exactly AMBER_SEC seconds (default 10). The yellow phase then turns red, and in the same cycle the requesting phase turns green.
- R7: Without a request from the red phase, the served phase keeps green indefinitely. Sensors on the green phase's own approaches have no effect.
- R8: A request is latched. Releasing the sensor during the wait does not cancel the change of phase.
- R9: At no time are both phases non-red.
- R10: Bit mapping for `sensor` and `lamp`: bit 0 north, bit 1 south, bit 2 east, bit 3 west. Bits 0–1 form one phase and bits 2–3 form the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor | input | 4 | Road sensors, one per approach (asynchronous) |
| lamp | output | 4 | One-colour lamp per approach, pattern-encoded colour |

## Verification
The hardest situation to reach is the exact edge of the latched wait: a sensor pulse that is released mid-wait, followed by the moment the served phase leaves green. The flash toggles run freely and are not aligned to the state change. The bench therefore classifies each lamp over short windows, counting transitions, rather than at single cycles. It places a steady-high 8-cycle window just before the 5-second mark and a 2 Hz window just after it, with the sensor already released. A mid-run reset then shows the flash counters restarting from zero.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
  typedef enum logic [1:0] {
    COL_RED = 2'd0,
    COL_YEL = 2'd1,
    COL_GRN = 2'd2
  } col_e;

  typedef enum logic [1:0] {
    ST_SERVE = 2'd0,
    ST_HOLD  = 2'd1,
    ST_AMBER = 2'd2
  } st_e;
endpackage

// File: rtl/sigc_sync.sv
module sigc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/sigc_timebase.sv
module sigc_timebase #(
  parameter int TICKS_PER_SEC = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic sec_tick,
  output logic blink_slow,
  output logic blink_fast
);
  localparam int EIGHTH   = TICKS_PER_SEC / 8;
  localparam int EIGHTH_W = (EIGHTH > 1) ? $clog2(EIGHTH) : 1;
  localparam int SEC_W    = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  logic [EIGHTH_W-1:0] eighth_cnt;
  logic [2:0]          slot_q;
  logic [SEC_W-1:0]    sec_cnt;
  logic                eighth_wrap;

  assign eighth_wrap = (eighth_cnt == EIGHTH_W'(EIGHTH - 1));
  assign sec_tick    = (sec_cnt == SEC_W'(TICKS_PER_SEC - 1));

  // free-running flash dividers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eighth_cnt <= '0;
      slot_q     <= '0;
      blink_fast <= 1'b0;
      blink_slow <= 1'b0;
    end else if (eighth_wrap) begin
      eighth_cnt <= '0;
      slot_q     <= slot_q + 3'd1;
      blink_fast <= ~blink_fast;
      if (slot_q[0]) blink_slow <= ~blink_slow;
    end else begin
      eighth_cnt <= eighth_cnt + 1'b1;
    end
  end

  // second divider, realigned on every state change
  always_ff @(posedge clk) begin
    if (!rst_n || restart || sec_tick) sec_cnt <= '0;
    else                               sec_cnt <= sec_cnt + 1'b1;
  end
endmodule

// File: rtl/sigc_phase_fsm.sv
module sigc_phase_fsm
  import sigc_pkg::*;
#(
  parameter int WAIT_SEC  = 5,
  parameter int AMBER_SEC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_ns,
  input  logic req_ew,
  input  logic sec_tick,
  output logic restart,
  output st_e  state,
  output col_e col_ns,
  output col_e col_ew
);
  localparam int MAXS   = (WAIT_SEC > AMBER_SEC) ? WAIT_SEC : AMBER_SEC;
  localparam int SECS_W = $clog2(MAXS + 1);

  st_e               state_n;
  logic              serve_ew, serve_ew_n;
  logic [SECS_W-1:0] secs;
  logic              red_req;
  col_e              served_col;

  assign red_req = serve_ew ? req_ns : req_ew;

  always_comb begin
    state_n    = state;
    serve_ew_n = serve_ew;
    unique case (state)
      ST_SERVE: if (red_req) state_n = ST_HOLD;
      ST_HOLD:  if (sec_tick && secs == SECS_W'(WAIT_SEC - 1)) state_n = ST_AMBER;
      ST_AMBER: if (sec_tick && secs == SECS_W'(AMBER_SEC - 1)) begin
        state_n    = ST_SERVE;
        serve_ew_n = ~serve_ew;
      end
      default:  state_n = ST_SERVE;
    endcase
  end

  assign restart = (state_n != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_SERVE;
      serve_ew <= 1'b0;
      secs     <= '0;
    end else begin
      state    <= state_n;
      serve_ew <= serve_ew_n;
      if (restart)                          secs <= '0;
      else if (sec_tick && state != ST_SERVE) secs <= secs + 1'b1;
    end
  end

  assign served_col = (state == ST_AMBER) ? COL_YEL : COL_GRN;
  assign col_ns     = serve_ew ? COL_RED : served_col;
  assign col_ew     = serve_ew ? served_col : COL_RED;
endmodule

// File: rtl/sigc_lamp_enc.sv
module sigc_lamp_enc
  import sigc_pkg::*;
(
  input  col_e col,
  input  logic blink_slow,
  input  logic blink_fast,
  output logic lamp
);
  always_comb begin
    unique case (col)
      COL_GRN: lamp = 1'b1;
      COL_YEL: lamp = blink_slow;
      default: lamp = blink_fast;
    endcase
  end
endmodule

// File: rtl/sig_ctrl_top.sv
module sig_ctrl_top
  import sigc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int WAIT_SEC      = 5,
  parameter int AMBER_SEC     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sensor,
  output logic [3:0] lamp
);
  localparam int NUM_APP = 4;

  logic [NUM_APP-1:0] sensor_s;
  logic               sec_tick, blink_slow, blink_fast, restart;
  st_e                state;
  col_e               col_ns, col_ew;
  col_e               app_col [NUM_APP];

  sigc_sync #(.W(NUM_APP)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sensor), .d_sync(sensor_s)
  );

  sigc_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tb (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .sec_tick(sec_tick), .blink_slow(blink_slow), .blink_fast(blink_fast)
  );

  sigc_phase_fsm #(.WAIT_SEC(WAIT_SEC), .AMBER_SEC(AMBER_SEC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_ns(sensor_s[0] | sensor_s[1]),
    .req_ew(sensor_s[2] | sensor_s[3]),
    .sec_tick(sec_tick), .restart(restart), .state(state),
    .col_ns(col_ns), .col_ew(col_ew)
  );

  // R10: bits 0,1 north/south phase, bits 2,3 east/west phase
  for (genvar a = 0; a < NUM_APP; a++) begin : g_app
    assign app_col[a] = (a < 2) ? col_ns : col_ew;
    sigc_lamp_enc u_enc (
      .col(app_col[a]), .blink_slow(blink_slow), .blink_fast(blink_fast),
      .lamp(lamp[a])
    );
  end
endmodule

// File: rtl/sigc_checker.sv
module sigc_checker
  import sigc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] lamp,
  input col_e       col_ns,
  input col_e       col_ew,
  input st_e        state
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (lamp == 4'b0011));

  assert_green_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ns == COL_GRN) |-> (lamp[1:0] == 2'b11));

  assert_green_exits_via_yellow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ns == COL_GRN) |=> (col_ns != COL_RED));

  assert_yellow_to_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ew == COL_YEL) |=> (col_ew == COL_YEL || col_ew == COL_RED));

  assert_request_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_AMBER));

  assert_one_phase_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ns == COL_RED) || (col_ew == COL_RED));
endmodule

bind sig_ctrl_top sigc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lamp(lamp),
  .col_ns(col_ns), .col_ew(col_ew), .state(state)
);

// File: tb/test_sig_ctrl_top.sv
module test_sig_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 16;
  localparam int NVEC       = 8;
  // colour codes used by the bench: 0 red, 1 yellow, 2 green
  // vector: {sensor[3:0], hold[9:0], exp_ns[1:0], exp_ew[1:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {4'b0000, 10'd4,   2'd2, 2'd0},  // R1 R7
    {4'b0001, 10'd100, 2'd2, 2'd0},  // R7 green-side sensor ignored
    {4'b0100, 10'd10,  2'd2, 2'd0},  // R5 wait keeps green
    {4'b0000, 10'd62,  2'd1, 2'd0},  // R8 R3 released, still yellow
    {4'b0000, 10'd150, 2'd0, 2'd2},  // R6 R4 swapped
    {4'b0010, 10'd8,   2'd0, 2'd2},  // R10 south request, waiting
    {4'b0000, 10'd70,  2'd0, 2'd1},  // R5 east/west yellow
    {4'b0000, 10'd150, 2'd2, 2'd0}   // R6 back to north/south
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sensor = 4'b0000;
  logic [3:0] lamp;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  int         tog [4];
  bit         allhi [4];

  sig_ctrl_top #(.TICKS_PER_SEC(TPS), .WAIT_SEC(5), .AMBER_SEC(10)) i_sig_ctrl_top (
    .clk(clk), .rst_n(rst_n), .sensor(sensor), .lamp(lamp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n);
    logic [3:0] prev;
    prev = lamp;
    for (int a = 0; a < 4; a++) begin tog[a] = 0; allhi[a] = lamp[a]; end
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int a = 0; a < 4; a++) begin
        if (lamp[a] != prev[a]) tog[a]++;
        if (!lamp[a]) allhi[a] = 1'b0;
      end
      prev = lamp;
    end
  endtask

  function automatic int classify(input int a, input int n);
    if (allhi[a] && tog[a] == 0) return 2;
    if (tog[a] == n / 4)         return 1;
    if (tog[a] == n / 2)         return 0;
    return 3;
  endfunction

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1";
      1: return "R7";
      2: return "R5";
      3: return "R8";
      4: return "R6";
      5: return "R10";
      6: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(lamp == 4'b0011, "R1 lamp after reset", lamp, 4'b0011);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      sensor = VEC[i][17:14];
      repeat (int'(VEC[i][13:4])) @(negedge clk);
      measure(16);
      for (int a = 0; a < 4; a++) begin
        int exp_c;
        exp_c = (a < 2) ? int'(VEC[i][3:2]) : int'(VEC[i][1:0]);
        check(classify(a, 16) == exp_c, vec_tag(i), classify(a, 16), exp_c);
      end
    end

    // R5 boundary and R8 latch: west pulse, released after 5 cycles
    sensor = 4'b1000;
    repeat (5) @(negedge clk);
    sensor = 4'b0000;
    repeat (67) @(negedge clk);
    measure(8);                       // cycles 72..80: still green
    check(classify(0, 8) == 2, "R5 green before wait end", classify(0, 8), 2);
    check(classify(3, 8) == 0, "R4 west red during wait", classify(3, 8), 0);
    repeat (4) @(negedge clk);
    measure(16);                      // cycles 84..100: yellow
    check(classify(1, 16) == 1, "R8 south yellow after released request", classify(1, 16), 1);
    repeat (120) @(negedge clk);
    measure(16);                      // cycles 220..236: still yellow
    check(classify(0, 16) == 1, "R6 yellow held", classify(0, 16), 1);
    repeat (10) @(negedge clk);
    measure(16);                      // cycles 246..262: swapped
    check(classify(0, 16) == 0, "R6 north red after yellow", classify(0, 16), 0);
    check(classify(2, 16) == 2, "R6 east green after yellow", classify(2, 16), 2);

    // R1 mid-run reset: counters and toggles cleared
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(lamp == 4'b0011, "R1 lamp during reset", lamp, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    check(lamp[3:2] == 2'b00, "R1 east/west low first eighth", lamp[3:2], 0);
    @(negedge clk);
    check(lamp[3:2] == 2'b11, "R1 east/west high second eighth", lamp[3:2], 3);
    measure(16);
    check(classify(1, 16) == 2, "R2 south green after reset", classify(1, 16), 2);
    check(classify(3, 16) == 0, "R9 west red while north/south green", classify(3, 16), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule